// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block buffers 9-bit words between a write clock and an unrelated read clock. Writes and reads are qualified by active-low enables. The write side needs two enables, and the read side needs two. The write and read pointers are one bit wider than the storage address. They cross between the two clock domains as Gray code through two-flop synchronisers. Full and empty flags are derived from the synchronised pointer difference.

Two programmable thresholds drive an almost-empty flag and an almost-full flag. Both are evaluated in the write domain. The thresholds are 18-bit offset registers that are written 9 bits at a time through the data input. A shared input pin has its role captured while reset is held. If it is held high during reset, it acts afterwards as a second write enable. If it is held low during reset, it acts as the strobe that loads the offset registers. An output-enable input selects whether the read data is driven or reported as high impedance. High impedance is modelled by an indicator output and a zeroed data bus.

Top module: `dualclk_flag_fifo`

## Requirements
- R1: While `rst_n` is low on both clocks, the FIFO is placed in the empty state. After release, `empty_n`=0, `full_n`=1, `aempty_n`=0, `afull_n`=1 and the registered read data is 0.
- R2: Accepted words leave in the order they were written, with no loss and no duplication.
- R3: `full_n` goes low when DEPTH words are unread. A write attempted while it is low does not change the contents.
- R4: `empty_n` goes low when no word is unread, and it changes only on rising `rd_clk` edges. A read attempted while it is low leaves `dout` unchanged.
- R5: In enable mode, a word is written only when `wr_en1_n` and `wr_en2_ld_n` are both low. A word is read only when `rd_en1_n` and `rd_en2_n` are both low. Either enable high alone blocks the transfer.
- R6: The level of `wr_en2_ld_n` while reset is applied selects the mode: 1 selects enable mode and 0 selects load mode. In load mode, `wr_en1_n`=0 with the pin at 0 loads an offset byte and writes no data word. `wr_en1_n`=0 with the pin at 1 writes a data word.
- R7: Offset loads fill the bytes in a fixed rotation: almost-empty bits 8:0, almost-empty bits 17:9, almost-full bits 8:0, almost-full bits 17:9. The fifth load goes back to almost-empty bits 8:0.
- R8: `afull_n` is low exactly while the unread count is at least DEPTH minus the almost-full offset. It is derived from write-clock registers.
- R9: `aempty_n` is low while the unread count is at most the almost-empty offset. It is registered by one `wr_clk` flop.
- R10: With `oe_n`=1, `dout_drive`=0 and `dout`=0. With `oe_n`=0, `dout_drive`=1 and `dout` shows the last word read.
- R11: After reset, both offsets equal the parameter DEF_OFS (4 by default, with DEPTH 16).
- R12: Each Gray pointer changes in at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled by both clocks |
| wr_en1_n | input | 1 | First write enable, active low |
| wr_en2_ld_n | input | 1 | Second write enable or offset-load strobe, role captured during reset |
| din | input | 9 | Write data and offset byte |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 9 | Read data, zero while not driven |
| dout_drive | output | 1 | 1 when `dout` is driven, 0 when modelled as high impedance |
| full_n | output | 1 | Low when full |
| empty_n | output | 1 | Low when empty |
| afull_n | output | 1 | Low when almost full |
| aempty_n | output | 1 | Low when almost empty |

## Verification
A write pointer that is wrong by one shows up in three ways. The read stream skips or repeats a word, `empty_n` rises or falls at a level other than the one expected, or the flag thresholds move. Each of these is visible within a few cycles of both clocks after the faulty write. An offset register that takes the wrong byte slot moves the `aempty_n` or `afull_n` transition by a whole threshold, and this shows at the first fill level that crosses the threshold. A latched mode that is wrong either lets load strobes become data words or blocks data writes entirely. Either case is seen as an early `empty_n` rise or one that never comes.

// File: rtl/dcf_pkg.sv
// Package: shared types for the dual-clock flag FIFO.
// Assumes: offset registers are two data words wide.
package dcf_pkg;
    // Rotation slot for offset byte loading; the order is behavioural.
    typedef enum logic [1:0] {
        SLOT_AE_LO = 2'd0,
        SLOT_AE_HI = 2'd1,
        SLOT_AF_LO = 2'd2,
        SLOT_AF_HI = 2'd3
    } ofs_slot_e;
endpackage

// File: rtl/dcf_ptr_sync.sv
// Module: two-flop synchroniser for a Gray pointer, with binary decode.
// Assumes: gray_in changes at most one bit per source clock edge.
module dcf_ptr_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage capture into the destination clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    // Gray to binary conversion of the synchronised value.
    always_comb begin
        bin_out[W-1] = sync_q[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ sync_q[i];
        end
    end
endmodule

// File: rtl/dcf_wr_side.sv
// Module: write domain of the FIFO. It holds the write pointer, the mode latch,
// the offset registers, and the full and programmable flags.
// Assumes: rptr_bin is already synchronised to clk; OFS_W = 2*DATA_W.
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int DATA_W  = 9,
    parameter int ADDR_W  = 4,
    parameter int DEF_OFS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en1_n,
    input  logic              en2_ld_n,
    input  logic [DATA_W-1:0] din,
    input  logic [ADDR_W:0]   rptr_bin,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W:0]   wptr,
    output logic [ADDR_W:0]   wgray,
    output logic [ADDR_W:0]   level,
    output logic              ld_mode,
    output logic              full_n,
    output logic              afull_n,
    output logic              aempty_n
);
    localparam int CNT_W = ADDR_W + 1;
    localparam int OFS_W = 2 * DATA_W;
    localparam int CMP_W = OFS_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [CNT_W-1:0] wptr_q, wptr_nxt, wgray_q;
    logic [OFS_W-1:0] ae_ofs_q, af_ofs_q;
    ofs_slot_e        slot_q;
    logic             mode_ld_q, ae_n_q;
    logic             wr_fire, ld_fire;
    logic [CMP_W-1:0] lvl_x;

    assign level    = wptr_q - rptr_bin;
    assign full_n   = (level != CNT_W'(DEPTH));
    assign wr_fire  = full_n && !en1_n && (mode_ld_q ? en2_ld_n : !en2_ld_n);
    assign ld_fire  = mode_ld_q && !en1_n && !en2_ld_n;
    assign wptr_nxt = wptr_q + 1'b1;
    assign lvl_x    = CMP_W'(level);

    // Capture the role of the shared pin while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_ld_q <= !en2_ld_n;
    end

    // Advance the binary and Gray write pointers on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            wgray_q <= '0;
        end else if (wr_fire) begin
            wptr_q  <= wptr_nxt;
            wgray_q <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end

    // Load offset bytes in rotating slot order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ae_ofs_q <= OFS_W'(DEF_OFS);
            af_ofs_q <= OFS_W'(DEF_OFS);
            slot_q   <= SLOT_AE_LO;
        end else if (ld_fire) begin
            case (slot_q)
                SLOT_AE_LO: ae_ofs_q[DATA_W-1:0]     <= din;
                SLOT_AE_HI: ae_ofs_q[OFS_W-1:DATA_W] <= din;
                SLOT_AF_LO: af_ofs_q[DATA_W-1:0]     <= din;
                default:    af_ofs_q[OFS_W-1:DATA_W] <= din;
            endcase
            slot_q <= ofs_slot_e'(slot_q + 2'd1);
        end
    end

    // Almost-empty flag, registered once in the write domain.
    always_ff @(posedge clk) begin
        if (!rst_n) ae_n_q <= 1'b0;
        else        ae_n_q <= !(lvl_x <= {1'b0, ae_ofs_q});
    end

    assign afull_n  = !((lvl_x + {1'b0, af_ofs_q}) >= CMP_W'(DEPTH));
    assign aempty_n = ae_n_q;
    assign mem_we   = wr_fire;
    assign mem_addr = wptr_q[ADDR_W-1:0];
    assign wptr     = wptr_q;
    assign wgray    = wgray_q;
    assign ld_mode  = mode_ld_q;
endmodule

// File: rtl/dcf_rd_side.sv
// Module: read domain of the FIFO. It holds the read pointer, the empty flag
// and the output data register.
// Assumes: wptr_bin is already synchronised to clk; rdata is the array word at rd_addr.
module dcf_rd_side #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en1_n,
    input  logic              en2_n,
    input  logic [ADDR_W:0]   wptr_bin,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W:0]   rgray,
    output logic              empty_n,
    output logic [DATA_W-1:0] data_q
);
    logic [ADDR_W:0] rptr_q, rptr_nxt;
    logic            rd_fire;

    assign empty_n  = (rptr_q != wptr_bin);
    assign rd_fire  = empty_n && !en1_n && !en2_n;
    assign rptr_nxt = rptr_q + 1'b1;
    assign rd_addr  = rptr_q[ADDR_W-1:0];

    // Advance the read pointer and register the word that leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_q <= '0;
            rgray  <= '0;
            data_q <= '0;
        end else if (rd_fire) begin
            rptr_q <= rptr_nxt;
            rgray  <= rptr_nxt ^ (rptr_nxt >> 1);
            data_q <= rdata;
        end
    end
endmodule

// File: rtl/dualclk_flag_fifo.sv
// Module: top of the dual-clock FIFO with programmable flags.
// Assumes: rst_n is held low for several edges of both clocks.
module dualclk_flag_fifo #(
    parameter int DATA_W  = 9,
    parameter int ADDR_W  = 4,
    parameter int DEF_OFS = 4
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en1_n,
    input  logic              wr_en2_ld_n,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_en1_n,
    input  logic              rd_en2_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_drive,
    output logic              full_n,
    output logic              empty_n,
    output logic              afull_n,
    output logic              aempty_n
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] dout_q, rdata;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [ADDR_W:0]   wptr, wgray, rgray, wr_level, rptr_sync, wptr_sync;
    logic              wr_we, ld_mode;

    dcf_wr_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEF_OFS(DEF_OFS)) wr_i (
        .clk(wr_clk), .rst_n(rst_n), .en1_n(wr_en1_n), .en2_ld_n(wr_en2_ld_n),
        .din(din), .rptr_bin(rptr_sync), .mem_we(wr_we), .mem_addr(wr_addr),
        .wptr(wptr), .wgray(wgray), .level(wr_level), .ld_mode(ld_mode),
        .full_n(full_n), .afull_n(afull_n), .aempty_n(aempty_n)
    );

    dcf_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) rd_i (
        .clk(rd_clk), .rst_n(rst_n), .en1_n(rd_en1_n), .en2_n(rd_en2_n),
        .wptr_bin(wptr_sync), .rdata(rdata), .rd_addr(rd_addr), .rgray(rgray),
        .empty_n(empty_n), .data_q(dout_q)
    );

    dcf_ptr_sync #(.W(ADDR_W + 1)) r2w_i (
        .clk(wr_clk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rptr_sync)
    );

    dcf_ptr_sync #(.W(ADDR_W + 1)) w2r_i (
        .clk(rd_clk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wptr_sync)
    );

    // Storage array, written in the write domain.
    always_ff @(posedge wr_clk) begin
        if (wr_we) mem_q[wr_addr] <= din;
    end

    assign rdata      = mem_q[rd_addr];
    assign dout       = oe_n ? '0 : dout_q;
    assign dout_drive = !oe_n;
endmodule

// File: rtl/dcf_checker.sv
// Module: assertion checker bound to dualclk_flag_fifo.
// Assumes: it is connected to the top-level nets named in the bind below.
module dcf_checker #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 4
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst_n,
    input logic              wr_en1_n,
    input logic              wr_en2_ld_n,
    input logic              rd_en1_n,
    input logic              rd_en2_n,
    input logic              ld_mode,
    input logic              full_n,
    input logic              empty_n,
    input logic [ADDR_W:0]   wptr,
    input logic [ADDR_W:0]   wgray,
    input logic [ADDR_W:0]   rgray,
    input logic [ADDR_W:0]   wr_level,
    input logic [DATA_W-1:0] dout_q
);
    localparam int DEPTH = 1 << ADDR_W;

    AST_NO_WR_WHEN_FULL: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |=> $stable(wptr));                                             // R3
    AST_LEVEL_BOUND: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_level <= (ADDR_W + 1)'(DEPTH));                                      // R3
    AST_NO_RD_WHEN_EMPTY: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |=> $stable(dout_q));                                          // R4
    AST_ONE_EN_NO_WRITE: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!ld_mode && wr_en2_ld_n) |=> $stable(wptr));                           // R5
    AST_ONE_REN_NO_READ: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_en1_n || rd_en2_n) |=> $stable(dout_q));                            // R5
    AST_LOAD_NO_DATA: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (ld_mode && !wr_en1_n && !wr_en2_ld_n) |=> $stable(wptr));              // R6
    AST_WGRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);                                 // R12
    AST_RGRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);                                 // R12
endmodule

bind dualclk_flag_fifo dcf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en1_n(wr_en1_n),
    .wr_en2_ld_n(wr_en2_ld_n), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
    .ld_mode(ld_mode), .full_n(full_n), .empty_n(empty_n), .wptr(wptr),
    .wgray(wgray), .rgray(rgray), .wr_level(wr_level), .dout_q(dout_q)
);

// File: tb/dualclk_flag_fifo_tb_top.sv
`timescale 1ns/1ps
module dualclk_flag_fifo_tb_top;
    logic       wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic       wr_en1_n = 1'b1, wr_en2_ld_n = 1'b1, rd_en1_n = 1'b1, rd_en2_n = 1'b1;
    logic       oe_n = 1'b0;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       dout_drive, full_n, empty_n, afull_n, aempty_n;

    int         n_checks = 0, n_errors = 0;
    bit         tb_ld = 1'b0;
    logic [8:0] model_q[$];
    logic [8:0] last_rd = '0;

    // Fill level {5 bits} then expected {aempty_n, afull_n, full_n, empty_n}; offsets 4, DEPTH 16.
    localparam logic [8:0] VEC_TAB [8] = '{
        {5'd0,  4'b0110}, {5'd1,  4'b0111}, {5'd4,  4'b0111}, {5'd5,  4'b1111},
        {5'd11, 4'b1111}, {5'd12, 4'b1011}, {5'd15, 4'b1011}, {5'd16, 4'b1001}
    };

    always #2.5 wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    dualclk_flag_fifo dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en1_n(wr_en1_n),
        .wr_en2_ld_n(wr_en2_ld_n), .din(din), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
        .oe_n(oe_n), .dout(dout), .dout_drive(dout_drive), .full_n(full_n),
        .empty_n(empty_n), .afull_n(afull_n), .aempty_n(aempty_n)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge rd_clk);
        repeat (8) @(negedge wr_clk);
    endtask

    task automatic do_reset(input bit ld);
        tb_ld = ld;
        @(negedge wr_clk);
        rst_n = 1'b0; wr_en1_n = 1'b1; wr_en2_ld_n = !ld;
        rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        repeat (10) @(negedge wr_clk);
        rst_n = 1'b1; wr_en2_ld_n = 1'b1;
        model_q.delete();
        last_rd = '0;
        settle();
    endtask

    // Data write: enable mode uses both enables low; load mode uses the pin high.
    task automatic put(input logic [8:0] v);
        @(negedge wr_clk);
        din = v; wr_en1_n = 1'b0; wr_en2_ld_n = tb_ld ? 1'b1 : 1'b0;
        @(negedge wr_clk);
        wr_en1_n = 1'b1; wr_en2_ld_n = 1'b1;
        if (full_n || model_q.size() < 16) model_q.push_back(v);
    endtask

    task automatic load_byte(input logic [8:0] v);
        @(negedge wr_clk);
        din = v; wr_en1_n = 1'b0; wr_en2_ld_n = 1'b0;
        @(negedge wr_clk);
        wr_en1_n = 1'b1; wr_en2_ld_n = 1'b1;
    endtask

    task automatic get(output logic [8:0] v);
        @(negedge rd_clk);
        rd_en1_n = 1'b0; rd_en2_n = 1'b0;
        @(negedge rd_clk);
        rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        v = dout;
    endtask

    task automatic flags(input string tag, input logic [3:0] exp);
        check({tag, " R9 aempty_n"}, int'(aempty_n), int'(exp[3]));
        check({tag, " R8 afull_n"},  int'(afull_n),  int'(exp[2]));
        check({tag, " R3 full_n"},   int'(full_n),   int'(exp[1]));
        check({tag, " R4 empty_n"},  int'(empty_n),  int'(exp[0]));
    endtask

    initial begin
        repeat (100000) @(posedge wr_clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [8:0] v;
        int written;
        do_reset(1'b0);
        // R1 reset state
        check("R1 empty_n", int'(empty_n), 0);
        check("R1 full_n", int'(full_n), 1);
        check("R1 aempty_n", int'(aempty_n), 0);
        check("R1 afull_n", int'(afull_n), 1);
        check("R1 dout", int'(dout), 0);

        // Table walk: fill levels against default offsets (R11, R8, R9, R3).
        written = 0;
        for (int i = 0; i < 8; i++) begin
            while (written < int'(VEC_TAB[i][8:4])) begin
                put(9'h100 + 9'(written * 7));
                written++;
            end
            settle();
            flags($sformatf("R11 fill=%0d", written), VEC_TAB[i][3:0]);
        end

        // R3: write while full is ignored.
        put(9'h155);
        settle();
        check("R3 full after extra write", int'(full_n), 0);

        // R2: read back in order; 16 words only.
        for (int k = 0; k < 16; k++) begin
            get(v);
            check("R2 data order", int'(v), int'(model_q.pop_front()));
            last_rd = v;
        end
        settle();
        check("R4 empty after drain", int'(empty_n), 0);
        get(v);
        check("R4 read at empty keeps dout", int'(v), int'(last_rd));

        // R10: output enable.
        @(negedge rd_clk); oe_n = 1'b1;
        @(negedge rd_clk);
        check("R10 drive off", int'(dout_drive), 0);
        check("R10 dout zero", int'(dout), 0);
        oe_n = 1'b0;
        @(negedge rd_clk);
        check("R10 drive on", int'(dout_drive), 1);
        check("R10 dout last", int'(dout), int'(last_rd));

        // R5: one write enable alone writes nothing.
        @(negedge wr_clk); din = 9'h0AB; wr_en1_n = 1'b0; wr_en2_ld_n = 1'b1;
        repeat (3) @(negedge wr_clk);
        wr_en1_n = 1'b1;
        settle();
        check("R5 single write enable blocked", int'(empty_n), 0);
        put(9'h0AB);
        settle();
        check("R5 both enables write", int'(empty_n), 1);
        @(negedge rd_clk); rd_en1_n = 1'b0; rd_en2_n = 1'b1;
        repeat (3) @(negedge rd_clk);
        rd_en1_n = 1'b1;
        settle();
        check("R5 single read enable blocked dout", int'(dout), int'(last_rd));
        check("R5 single read enable blocked empty", int'(empty_n), 1);
        get(v);
        check("R2 word after blocked read", int'(v), 9'h0AB);
        void'(model_q.pop_front());

        // R6, R7: load mode with wrap of the rotation; n=3, m=9.
        do_reset(1'b1);
        load_byte(9'd2); load_byte(9'd0); load_byte(9'd9); load_byte(9'd0); load_byte(9'd3);
        settle();
        check("R6 load strobes write no data", int'(empty_n), 0);
        for (int k = 0; k < 3; k++) put(9'h040 + 9'(k));
        settle();
        check("R6 pin high writes data", int'(empty_n), 1);
        check("R7 aempty_n at 3 with wrapped n=3", int'(aempty_n), 0);
        put(9'h043);
        settle();
        check("R7 aempty_n at 4 with n=3", int'(aempty_n), 1);
        put(9'h044); put(9'h045);
        settle();
        check("R8 afull_n at 6 with m=9", int'(afull_n), 1);
        put(9'h046);
        settle();
        check("R8 afull_n at 7 with m=9", int'(afull_n), 0);
        get(v);
        check("R6 first data word", int'(v), 9'h040);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule